// File: doc/BRIEF.md
# Wildcard Time Alarm Comparator

This block watches the current seconds, minutes and hours of a real-time clock and raises a one-cycle alarm event when the once-per-second update finishes and the time matches three alarm bytes. Any alarm byte can be a wildcard that matches every value of its field. With a wildcard the alarm can fire every second, every minute or every hour. The time counter, interrupt masking and register access sit outside this block. The block takes the raw register bytes, the two format bits and the update-finished pulse.

Both sides of each comparison are first turned into plain binary numbers under the format in force: BCD or binary, and 12-hour or 24-hour. Two encodings of the same instant therefore compare equal. The alarm bytes are compared live, so a newly written alarm value counts from the very next update. While the clock dividers are held stopped no update is taken, and no event is raised.

Top module: `alarm_cmp`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `alarm_evt` is 0.
- R2: With `bin_mode`=0 (BCD) and `hr24`=1, if every alarm byte equals its time byte when `upd_done` is sampled high, `alarm_evt` is 1 in the next cycle. A single differing field gives no event.
- R3: An alarm byte whose bits 7 and 6 are both 1 matches any value of its field. The other fields must still match.
- R4: If all three alarm bytes are wildcards, every `upd_done` pulse produces an event, whatever the time.
- R5: With `hr24`=0, an hour byte (alarm or current) has bit 7 as the PM flag. The rest of the byte is decoded, reduced modulo 12, and 12 is added when PM is set. So 0x92 means hour 12, 0x12 means hour 0, and alarm 0x00 matches current 0x12.
- R6: With `bin_mode`=1 bytes are plain binary. With `bin_mode`=0 a byte is worth 10 times its upper nibble plus its lower nibble. So 0x10 and 0x0A match in BCD mode but not in binary mode.
- R7: `alarm_evt` is high only in the cycle right after a sampled `upd_done`. A matching time with no pulse gives no event.
- R8: While `div_hold` is 1, an `upd_done` pulse produces no event.
- R9: The alarm bytes present in the cycle that `upd_done` is sampled are the ones used. A rewritten alarm takes effect at the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24 | input | 1 | 1 = 24-hour hours, 0 = 12-hour with bit 7 as PM |
| div_hold | input | 1 | Dividers held stopped; suppresses events |
| upd_done | input | 1 | One-cycle pulse at the end of each one-second update |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hour | input | 8 | Alarm hours byte |
| alarm_evt | output | 1 | One-cycle alarm event |

## Verification
On every cycle the bound checker confirms the following:
- The event is quiet in reset.
- The event appears only after a sampled update pulse with the dividers running.
- An all-wildcard alarm always fires.
- A byte-for-byte identical alarm always fires.

Only the directed scenarios can show the cases where raw bytes differ but decoded values agree or disagree. These are 12-hour folding, BCD against binary decoding, a partial wildcard, and an alarm rewritten between two pulses.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;

   typedef enum logic [1:0] {
      FLD_SEC  = 2'd0,
      FLD_MIN  = 2'd1,
      FLD_HOUR = 2'd2
   } fld_kind_e;

   typedef struct packed {
      logic       wild;
      logic [7:0] val;
   } fld_norm_t;

   // Decimal weight of a two-nibble byte: ten per upper nibble plus lower nibble.
   function automatic logic [7:0] nib_to_bin(input logic [7:0] b);
      return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
   endfunction

endpackage

// File: rtl/alarm_fld_decode.sv
module alarm_fld_decode
   import alarm_cmp_pkg::*;
#(
   parameter int            DATA_W     = 8,
   parameter fld_kind_e     KIND       = FLD_SEC,
   parameter bit            ALLOW_WILD = 1'b1,
   parameter logic [1:0]    WILD_CODE  = 2'b11
) (
   input  logic [DATA_W-1:0] raw,
   input  logic              bin_mode,
   input  logic              hr24,
   output fld_norm_t         norm
);

   localparam int TOP = DATA_W - 1;

   if (DATA_W != 8) begin : g_bad_width
      $error("alarm_fld_decode: DATA_W must be 8");
   end

   logic       wild;
   logic [7:0] dec;

   // Wildcard detection is a build-time option.
   if (ALLOW_WILD) begin : g_wild
      assign wild = (raw[TOP -: 2] == WILD_CODE);
   end else begin : g_nowild
      assign wild = 1'b0;
   end

   if (KIND == FLD_HOUR) begin : g_hour
      logic [7:0] body;
      logic [7:0] base;
      always_comb begin
         body = hr24 ? raw : {1'b0, raw[6:0]};
         base = bin_mode ? body : nib_to_bin(body);
         if (hr24) begin
            dec = base;
         end else begin
            dec = (base % 8'd12) + (raw[TOP] ? 8'd12 : 8'd0);
         end
      end
   end else begin : g_plain
      always_comb begin
         dec = bin_mode ? raw : nib_to_bin(raw);
      end
   end

   assign norm.wild = wild;
   assign norm.val  = dec;

endmodule

// File: rtl/alarm_fld_match.sv
module alarm_fld_match
   import alarm_cmp_pkg::*;
(
   input  fld_norm_t alm,
   input  fld_norm_t cur,
   output logic      hit
);

   logic same;

   always_comb begin
      same = (alm.val == cur.val) && !cur.wild;
      hit  = alm.wild || same;
   end

endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
   import alarm_cmp_pkg::*;
#(
   parameter int         DATA_W    = 8,
   parameter int         NUM_FLD   = 3,
   parameter logic [1:0] WILD_CODE = 2'b11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bin_mode,
   input  logic              hr24,
   input  logic              div_hold,
   input  logic              upd_done,
   input  logic [DATA_W-1:0] cur_sec,
   input  logic [DATA_W-1:0] cur_min,
   input  logic [DATA_W-1:0] cur_hour,
   input  logic [DATA_W-1:0] alm_sec,
   input  logic [DATA_W-1:0] alm_min,
   input  logic [DATA_W-1:0] alm_hour,
   output logic              alarm_evt
);

   localparam int HOUR_IDX = NUM_FLD - 1;

   if (NUM_FLD != 3) begin : g_bad_count
      $error("alarm_cmp: NUM_FLD must be 3 (sec, min, hour)");
   end
   if (DATA_W != 8) begin : g_bad_width
      $error("alarm_cmp: DATA_W must be 8");
   end

   logic [DATA_W-1:0] cur_raw [NUM_FLD];
   logic [DATA_W-1:0] alm_raw [NUM_FLD];
   fld_norm_t         cur_n   [NUM_FLD];
   fld_norm_t         alm_n   [NUM_FLD];
   logic [NUM_FLD-1:0] hit;

   assign cur_raw[0] = cur_sec;
   assign cur_raw[1] = cur_min;
   assign cur_raw[2] = cur_hour;
   assign alm_raw[0] = alm_sec;
   assign alm_raw[1] = alm_min;
   assign alm_raw[2] = alm_hour;

   for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
      localparam fld_kind_e K = (i == HOUR_IDX) ? FLD_HOUR :
                                (i == 1)        ? FLD_MIN  : FLD_SEC;

      alarm_fld_decode #(
         .DATA_W     (DATA_W),
         .KIND       (K),
         .ALLOW_WILD (1'b0),
         .WILD_CODE  (WILD_CODE)
      ) u_cur (
         .raw      (cur_raw[i]),
         .bin_mode (bin_mode),
         .hr24     (hr24),
         .norm     (cur_n[i])
      );

      alarm_fld_decode #(
         .DATA_W     (DATA_W),
         .KIND       (K),
         .ALLOW_WILD (1'b1),
         .WILD_CODE  (WILD_CODE)
      ) u_alm (
         .raw      (alm_raw[i]),
         .bin_mode (bin_mode),
         .hr24     (hr24),
         .norm     (alm_n[i])
      );

      alarm_fld_match u_match (
         .alm (alm_n[i]),
         .cur (cur_n[i]),
         .hit (hit[i])
      );
   end

   logic fire;
   assign fire = upd_done && !div_hold && (&hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_evt <= 1'b0;
      end else begin
         alarm_evt <= fire;
      end
   end

endmodule

// File: rtl/alarm_cmp_chk.sv
module alarm_cmp_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       div_hold,
   input logic       upd_done,
   input logic [7:0] cur_sec,
   input logic [7:0] cur_min,
   input logic [7:0] cur_hour,
   input logic [7:0] alm_sec,
   input logic [7:0] alm_min,
   input logic [7:0] alm_hour,
   input logic       alarm_evt
);

   // R1
   rst_quiet_chk: assert property (@(posedge clk) !rst_n |=> !alarm_evt);

   // R7
   evt_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_evt |-> $past(upd_done));

   // R8
   evt_not_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_evt |-> !$past(div_hold));

   // R4
   all_wild_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_done && !div_hold && (alm_sec[7:6] == 2'b11) &&
       (alm_min[7:6] == 2'b11) && (alm_hour[7:6] == 2'b11)) |=> alarm_evt);

   // R2
   exact_bytes_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_done && !div_hold && (alm_sec == cur_sec) &&
       (alm_min == cur_min) && (alm_hour == cur_hour)) |=> alarm_evt);

endmodule

bind alarm_cmp alarm_cmp_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .div_hold  (div_hold),
   .upd_done  (upd_done),
   .cur_sec   (cur_sec),
   .cur_min   (cur_min),
   .cur_hour  (cur_hour),
   .alm_sec   (alm_sec),
   .alm_min   (alm_min),
   .alm_hour  (alm_hour),
   .alarm_evt (alarm_evt)
);

// File: tb/sim_alarm_cmp.sv
module sim_alarm_cmp;

   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bin_mode = 1'b0;
   logic       hr24 = 1'b1;
   logic       div_hold = 1'b0;
   logic       upd_done = 1'b0;
   logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
   logic [7:0] alm_sec = 8'h01, alm_min = 8'h00, alm_hour = 8'h00;
   logic       alarm_evt;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alarm_cmp u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bin_mode  (bin_mode),
      .hr24      (hr24),
      .div_hold  (div_hold),
      .upd_done  (upd_done),
      .cur_sec   (cur_sec),
      .cur_min   (cur_min),
      .cur_hour  (cur_hour),
      .alm_sec   (alm_sec),
      .alm_min   (alm_min),
      .alm_hour  (alm_hour),
      .alarm_evt (alarm_evt)
   );

   task automatic chk(input logic got, input logic exp, input string req);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: alarm_evt=%b expected %b", req, got, exp);
      end
   endtask

   task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
      cur_hour = h; cur_min = m; cur_sec = s;
   endtask

   task automatic set_alarm(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
      alm_hour = h; alm_min = m; alm_sec = s;
   endtask

   // Pulse upd_done for one cycle and sample the event in the following cycle.
   task automatic pulse_chk(input logic exp, input string req);
      @(negedge clk);
      upd_done = 1'b1;
      @(negedge clk);
      upd_done = 1'b0;
      chk(alarm_evt, exp, req);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(alarm_evt, 1'b0, "R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(alarm_evt, 1'b0, "R1 after release");
   endtask

   task automatic t_exact_bcd();
      bin_mode = 1'b0; hr24 = 1'b1;
      set_time(8'h12, 8'h34, 8'h56);
      set_alarm(8'h12, 8'h34, 8'h56);
      pulse_chk(1'b1, "R2 exact match");
      @(negedge clk);
      chk(alarm_evt, 1'b0, "R7 single cycle");
      set_alarm(8'h12, 8'h34, 8'h57);
      pulse_chk(1'b0, "R2 seconds differ");
   endtask

   task automatic t_wild();
      set_time(8'h07, 8'h34, 8'h56);
      set_alarm(8'hC0, 8'h34, 8'h56);
      pulse_chk(1'b1, "R3 hour wildcard");
      set_time(8'h07, 8'h11, 8'h56);
      set_alarm(8'hC0, 8'hFF, 8'h56);
      pulse_chk(1'b1, "R3 hour+min wildcard");
      set_time(8'h07, 8'h11, 8'h55);
      pulse_chk(1'b0, "R3 seconds still compared");
   endtask

   task automatic t_all_wild();
      set_alarm(8'hC0, 8'hC5, 8'hFF);
      set_time(8'h00, 8'h00, 8'h00);
      pulse_chk(1'b1, "R4 every update a");
      set_time(8'h23, 8'h59, 8'h59);
      pulse_chk(1'b1, "R4 every update b");
      set_time(8'h09, 8'h41, 8'h17);
      pulse_chk(1'b1, "R4 every update c");
   endtask

   task automatic t_12h();
      hr24 = 1'b0; bin_mode = 1'b0;
      set_alarm(8'h92, 8'h00, 8'h00);
      set_time(8'h92, 8'h00, 8'h00);
      pulse_chk(1'b1, "R5 12 PM matches");
      set_time(8'h12, 8'h00, 8'h00);
      pulse_chk(1'b0, "R5 12 AM differs from 12 PM");
      set_alarm(8'h00, 8'h00, 8'h00);
      pulse_chk(1'b1, "R5 alarm 0x00 equals 0x12 modulo 12");
      hr24 = 1'b1;
   endtask

   task automatic t_binary();
      set_time(8'h01, 8'h02, 8'h0A);
      set_alarm(8'h01, 8'h02, 8'h10);
      bin_mode = 1'b0;
      pulse_chk(1'b1, "R6 BCD 0x10 equals 0x0A");
      bin_mode = 1'b1;
      pulse_chk(1'b0, "R6 binary 16 vs 10");
      set_time(8'h01, 8'h02, 8'h25);
      set_alarm(8'h01, 8'h02, 8'h25);
      pulse_chk(1'b1, "R6 binary equal");
      bin_mode = 1'b0;
   endtask

   task automatic t_hold();
      set_time(8'h05, 8'h06, 8'h07);
      set_alarm(8'h05, 8'h06, 8'h07);
      div_hold = 1'b1;
      pulse_chk(1'b0, "R8 held dividers");
      div_hold = 1'b0;
      pulse_chk(1'b1, "R8 released");
   endtask

   task automatic t_rearm();
      set_time(8'h10, 8'h20, 8'h30);
      set_alarm(8'h10, 8'h20, 8'h31);
      pulse_chk(1'b0, "R9 old alarm");
      set_alarm(8'h10, 8'h20, 8'h30);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(alarm_evt, 1'b0, "R7 match without pulse");
      end
      pulse_chk(1'b1, "R9 new alarm used");
   endtask

   initial begin
      t_reset();
      t_exact_bcd();
      t_wild();
      t_all_wild();
      t_12h();
      t_binary();
      t_hold();
      t_rearm();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule